// File: doc/BRIEF.md
# Quadrature-Window Phase Lock Detector

This block decides whether a clock-recovery loop is phase locked, and it reports how much of the incoming data jitters past the ideal edge. Logic upstream samples a quarter-UI-delayed clock at every data transition. That sampled bit is high when the transition landed inside a half-UI window centred on the ideal edge. The block receives the bit as `in_win_i`, qualified by the strobe `trans_i`.

Each qualified result is fed into a first-order exponential moving average. The average is held as an unsigned fixed-point fraction and starts at one half after reset. When the loop is unlocked, transitions fall at random phase and the average drifts back towards one half. When the loop is locked, nearly every transition is a hit and the average climbs towards one.

The lock flag is set when the average rises above a two-thirds threshold plus a small margin. It is cleared only when the average falls below the threshold minus the same margin, so the flag does not chatter when the average sits near the threshold. A jitter indicator gives the filtered miss fraction, which is the complement of the average, truncated to its upper bits. The filter constant is set by a shift parameter and should be chosen so that the time constant, counted in transitions, spans more than one video line.

Top module: `pld_lock_detect`

## Requirements
- R1: Reset behaviour.
  - While `rst_n` is low at a clock edge, the hit average is set to 2^(RATIO_W-1), which is one half.
  - `lock_o` reads 0.
  - `jitter_o` reads 2^(JIT_W-1)-1 (127 with the defaults).
- R2: In a cycle where `trans_i` is low, the hit average, `lock_o` and `jitter_o` keep their values.
- R3: A cycle with `trans_i` high and `in_win_i` high updates the average at the next edge to avg + ((2^RATIO_W-1-avg) >> SHIFT).
- R4: A cycle with `trans_i` high and `in_win_i` low updates the average at the next edge to avg - (avg >> SHIFT).
- R5: `lock_o` rises at the same edge at which the updated average becomes greater than THR_HI.
  - THR_MID = floor(2^RATIO_W * THR_PCT / 100), which is 43253 with the defaults.
  - THR_HI = THR_MID + HYST, which is 44277 with the defaults.
- R6: `lock_o` falls at the same edge at which the updated average becomes less than THR_LO = THR_MID - HYST (42229 with the defaults).
  - While the average stays between THR_LO and THR_HI inclusive, `lock_o` keeps its previous value.
- R7: `jitter_o` equals the upper JIT_W bits of (2^RATIO_W-1-avg), the filtered miss fraction. It follows the average with no extra register.
- R8: The average never wraps.
  - A long run of hits leaves it at or below 2^RATIO_W-1.
  - A long run of misses leaves it at or above 0.
- R9: `in_win_i` has no effect in a cycle where `trans_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trans_i | input | 1 | One-cycle strobe marking a data transition |
| in_win_i | input | 1 | Transition fell inside the quadrature window; valid with `trans_i` |
| lock_o | output | 1 | Phase-lock flag with hysteresis |
| jitter_o | output | JIT_W | Filtered fraction of transitions outside the window |

## Verification
The checks assume that `trans_i` and `in_win_i` are synchronous to `clk` and carry known values whenever reset is released. They also assume that `in_win_i` matters only while the strobe is high. The stimulus changes inputs only at falling edges. It toggles `in_win_i` freely during idle cycles to show that it is ignored there. It drives sustained hit runs, sustained miss runs, random fifty-percent phase, and fixed hit-to-miss mixes of 3:1 and 2:1. The 2:1 mix parks the average inside the hysteresis band, where the flag must hold its value.

// File: rtl/pld_pkg.sv
// Package: shared types for the phase lock detector.
// Assumes nothing beyond being compiled before the modules that import it.
package pld_pkg;

    // Lock decision state kept by the hysteresis comparator.
    typedef enum logic {
        PLD_UNLOCKED = 1'b0,
        PLD_LOCKED   = 1'b1
    } pld_lock_e;

endpackage

// File: rtl/pld_ema.sv
// Module: exponential moving average of window hits.
// The average moves 1/2^SHIFT of the way towards full scale on a hit, and
// towards zero on a miss, only on strobed cycles. Assumes SHIFT < W.
module pld_ema #(
    parameter int W     = 16,
    parameter int SHIFT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic         hit_i,
    output logic [W-1:0] ratio_o,
    output logic [W-1:0] ratio_next_o
);
    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] ratio_q;
    logic [W-1:0] gap;

    // Compute the next average from the current one and the strobed sample.
    always_comb begin
        gap = FULL - ratio_q;
        if (!strobe_i)
            ratio_next_o = ratio_q;
        else if (hit_i)
            ratio_next_o = ratio_q + (gap >> SHIFT);
        else
            ratio_next_o = ratio_q - (ratio_q >> SHIFT);
    end

    // Hold the average; reset starts it at one half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= HALF;
        else
            ratio_q <= ratio_next_o;
    end

    assign ratio_o = ratio_q;
endmodule

// File: rtl/pld_hyst_cmp.sv
// Module: threshold comparator with hysteresis.
// It sets the flag above HI and clears it below LO. Between the two it keeps
// the flag. It judges the next average, so the flag moves on the same edge
// as the average. Assumes LO <= HI.
module pld_hyst_cmp #(
    parameter int          W  = 16,
    parameter logic [15:0] HI = 16'd44277,
    parameter logic [15:0] LO = 16'd42229
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_next_i,
    output logic         lock_o
);
    import pld_pkg::*;

    localparam logic [W-1:0] HI_W = W'(HI);
    localparam logic [W-1:0] LO_W = W'(LO);

    pld_lock_e state_q, state_d;

    // Decide the next lock state from the next average.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PLD_UNLOCKED: if (ratio_next_i > HI_W) state_d = PLD_LOCKED;
            PLD_LOCKED:   if (ratio_next_i < LO_W) state_d = PLD_UNLOCKED;
            default:      state_d = PLD_UNLOCKED;
        endcase
    end

    // Register the lock state; reset leaves it unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PLD_UNLOCKED;
        else
            state_q <= state_d;
    end

    assign lock_o = (state_q == PLD_LOCKED);
endmodule

// File: rtl/pld_jitter_map.sv
// Module: maps the hit average to a miss-fraction indicator.
// The miss fraction is FULL - avg, which equals the bitwise complement of
// avg. Its top JW bits are taken. Assumes JW <= W.
module pld_jitter_map #(
    parameter int W  = 16,
    parameter int JW = 8
) (
    input  logic [W-1:0]  ratio_i,
    output logic [JW-1:0] jitter_o
);
    logic [W-1:0] miss;

    // Complement gives the miss fraction in the same scale.
    assign miss = ~ratio_i;

    // Select full width or upper slice depending on the parameters.
    generate
        if (JW == W) begin : g_full
            assign jitter_o = miss;
        end else begin : g_slice
            assign jitter_o = miss[W-1 -: JW];
        end
    endgenerate
endmodule

// File: rtl/pld_lock_detect.sv
// Module: quadrature-window phase lock detector (top).
// It filters strobed inside-window samples into a hit average and derives
// the lock flag and the jitter indicator from it. Assumes inputs are
// synchronous to clk and that in_win_i is meaningful only with trans_i.
module pld_lock_detect #(
    parameter int RATIO_W = 16,
    parameter int SHIFT   = 6,
    parameter int JIT_W   = 8,
    parameter int THR_PCT = 66,
    parameter int HYST    = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trans_i,
    input  logic             in_win_i,
    output logic             lock_o,
    output logic [JIT_W-1:0] jitter_o
);
    localparam longint THR_MID = ((longint'(1) << RATIO_W) * THR_PCT) / 100;
    localparam logic [15:0] THR_HI = 16'(THR_MID + HYST);
    localparam logic [15:0] THR_LO = 16'(THR_MID - HYST);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] ratio_next;

    // Filter stage: running hit average.
    pld_ema #(.W(RATIO_W), .SHIFT(SHIFT)) ema_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (trans_i),
        .hit_i        (in_win_i),
        .ratio_o      (ratio_q),
        .ratio_next_o (ratio_next)
    );

    // Decision stage: lock flag with hysteresis.
    pld_hyst_cmp #(.W(RATIO_W), .HI(THR_HI), .LO(THR_LO)) cmp_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ratio_next_i (ratio_next),
        .lock_o       (lock_o)
    );

    // Indicator stage: filtered miss fraction.
    pld_jitter_map #(.W(RATIO_W), .JW(JIT_W)) jit_i (
        .ratio_i  (ratio_q),
        .jitter_o (jitter_o)
    );
endmodule

// File: rtl/pld_lock_detect_chk.sv
// Checker: temporal properties of the lock detector, bound to the top.
// Assumes a synchronous active-low reset and known inputs after reset.
module pld_lock_detect_chk #(
    parameter int RATIO_W = 16,
    parameter int THR_PCT = 66,
    parameter int HYST    = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trans_i,
    input logic               in_win_i,
    input logic [RATIO_W-1:0] ratio,
    input logic               lock_o
);
    localparam longint THR_MID = ((longint'(1) << RATIO_W) * THR_PCT) / 100;
    localparam logic [RATIO_W-1:0] HI = RATIO_W'(THR_MID + HYST);
    localparam logic [RATIO_W-1:0] LO = RATIO_W'(THR_MID - HYST);

    // Without a strobe, the average and the flag hold (R2, R9).
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trans_i |=> ($stable(ratio) && $stable(lock_o)));

    // A hit never lowers the average, so it cannot wrap (R3, R8).
    assert_hit_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_i && in_win_i) |=> (ratio >= $past(ratio)));

    // A miss never raises the average, so it cannot underflow (R4, R8).
    assert_miss_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trans_i && !in_win_i) |=> (ratio <= $past(ratio)));

    // Lock only rises above the upper threshold (R5).
    assert_lock_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> (ratio > HI));

    // Lock only falls below the lower threshold (R6).
    assert_lock_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> (ratio < LO));
endmodule

bind pld_lock_detect pld_lock_detect_chk #(
    .RATIO_W (RATIO_W),
    .THR_PCT (THR_PCT),
    .HYST    (HYST)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trans_i  (trans_i),
    .in_win_i (in_win_i),
    .ratio    (ratio_q),
    .lock_o   (lock_o)
);

// File: tb/pld_lock_detect_tb.sv
// Bench: behavioural reference model compared against the outputs every clock.
module pld_lock_detect_tb_top;
    localparam int W  = 16;
    localparam int S  = 6;
    localparam int JW = 8;
    localparam int FULL   = 65535;
    localparam int THR_HI = 43253 + 1024;
    localparam int THR_LO = 43253 - 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trans_i = 1'b0;
    logic in_win_i = 1'b0;
    logic lock_o;
    logic [JW-1:0] jitter_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int m_avg  = 32768;
    bit m_lock = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    pld_lock_detect dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trans_i  (trans_i),
        .in_win_i (in_win_i),
        .lock_o   (lock_o),
        .jitter_o (jitter_o)
    );

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected at most 200000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Compare both outputs with the model; tag names the requirements.
    task automatic compare();
        int exp_j;
        exp_j = (FULL - m_avg) >> (W - JW);
        checks++;
        if (lock_o !== m_lock) begin
            fails++;
            $display("FAIL %s lock_o: actual %0b expected %0b", tag, lock_o, m_lock);
        end
        checks++;
        if (int'(jitter_o) != exp_j) begin
            fails++;
            $display("FAIL %s/R7 jitter_o: actual %0d expected %0d", tag, jitter_o, exp_j);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check at the next falling edge.
    task automatic step(input bit t, input bit w);
        trans_i  = t;
        in_win_i = w;
        if (t) begin
            if (w) m_avg = m_avg + ((FULL - m_avg) >> S);
            else   m_avg = m_avg - (m_avg >> S);
            if (m_avg > THR_HI) m_lock = 1'b1;
            else if (m_avg < THR_LO) m_lock = 1'b0;
        end
        @(negedge clk);
        compare();
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        tag = "R1";
        compare();
        rst_n = 1'b1;

        // R2, R9: idle cycles with the window bit toggling.
        tag = "R2/R9";
        for (int i = 0; i < 40; i++) step(1'b0, i[0]);

        // R3, R5: sustained hits, lock must rise.
        tag = "R3/R5";
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 1'b1);
            if (i % 3 == 0) step(1'b0, 1'b0);
        end
        tag = "R5";
        checks++;
        if (lock_o !== 1'b1) begin
            fails++;
            $display("FAIL R5 lock after hits: actual %0b expected 1", lock_o);
        end

        // R8: long hit run saturates without wrapping.
        tag = "R8";
        for (int i = 0; i < 1500; i++) step(1'b1, 1'b1);

        // R2/R9 while locked: idle toggling has no effect.
        tag = "R9";
        for (int i = 0; i < 20; i++) step(1'b0, ~i[0]);

        // R4, R6: random phase, average falls towards one half, lock drops.
        tag = "R4/R6";
        for (int i = 0; i < 3000; i++) step(1'b1, 1'($urandom_range(0, 1)));
        tag = "R6";
        checks++;
        if (lock_o !== 1'b0) begin
            fails++;
            $display("FAIL R6 lock after random phase: actual %0b expected 0", lock_o);
        end

        // R3/R4/R5: 3:1 hit mix relocks.
        tag = "R3/R4/R5";
        for (int i = 0; i < 1200; i++) step(1'b1, (i % 4) != 3);

        // R6: 2:1 mix sits near two thirds, inside the band, with the flag held.
        tag = "R6";
        for (int i = 0; i < 1500; i++) step(1'b1, (i % 3) != 2);

        // R4, R8: long miss run approaches zero without underflow.
        tag = "R4/R8";
        for (int i = 0; i < 2000; i++) step(1'b1, 1'b0);

        // R1: reset again returns to one half.
        tag = "R1";
        rst_n = 1'b0;
        m_avg = 32768;
        m_lock = 1'b0;
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule